// File: doc/BRIEF.md
# Serial Receiver with Per-Character Error Tags

This block recovers characters from one asynchronous serial line. A baud tick at sixteen times the bit rate paces it. The line is first synchronised, and a falling edge only counts as a start bit if the line is still low half a bit later. After that, each data, parity and stop bit is sampled once at the middle of the bit. A character has eight data bits sent LSB first. Parity can be none, even or odd, and the frame can end with one or two stop bits.

Every finished character goes into a four-deep queue as a 12-bit word made of the byte and four error tags, plus one extra address-tag bit. The oldest word is always visible on the read port, and a read strobe discards it. The queue reports when it is empty and when it is full. One interrupt line is driven when the visible word carries a tag that is enabled in a four-bit mask.

In idle-line multiprocessor mode, ten or more bit times of high line with no frame in progress raise an idle indication. The character that follows is tagged as an address.

Top module: `serial_rx_tagged`

## Requirements
- R1: `rd_data_o` shows the oldest stored word with the byte in [7:0], break in [11], framing in [10], parity in [9] and overrun in [8]. `rd_addr_o` shows its address tag. A high `rd_en_i` while not empty removes that word. Words leave in arrival order.
- R2: A low level on the line is taken as a start bit only if it is still low 8 ticks later. A low pulse of 3 ticks produces no word.
- R3: The framing tag is set when a stop bit is sampled low. When two stop bits are selected (`two_stop_i`=1), a low level in either stop bit sets it.
- R4: `par_mode_i` selects 0 = no parity bit, 1 = even, 2 = odd. The parity tag is set when the received parity bit does not match that rule over the eight data bits, and it is always clear when no parity bit is used.
- R5: The queue holds 4 words. A character that completes while the queue is full and no word is removed in the same cycle is dropped, and the overrun tag of the newest stored word is set. A removal in the same cycle as the completion lets the new word in without any overrun.
- R6: A frame whose start, data, parity and stop bits are all sampled 0 is stored as byte 0 with both the break and framing tags set. After that, no further start bit is searched for until the line has returned high.
- R7: `empty_o` is high exactly when no word is stored, and `full_o` is high exactly when 4 words are stored.
- R8: `irq_o` is high when the queue is not empty and the oldest word has a tag whose bit in `irq_mask_i` is set. Bit positions are [3] break, [2] framing, [1] parity, [0] overrun.
- R9: With `idle_mode_i` high, 10 bit times of high line outside a frame set `idle_o`. The next character is stored with its address tag set, which clears `idle_o`. Later characters are not tagged.
- R10: After reset the queue is empty and not full, and `irq_o` and `idle_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd_i | input | 1 | Serial line, idles high |
| par_mode_i | input | 2 | 0 none, 1 even, 2 odd |
| two_stop_i | input | 1 | Selects two stop bits |
| idle_mode_i | input | 1 | Enables idle-line address tagging |
| irq_mask_i | input | 4 | Interrupt enables: [3] break, [2] framing, [1] parity, [0] overrun |
| rd_en_i | input | 1 | Removes the oldest word |
| rd_data_o | output | 12 | Oldest word: tags [11:8], byte [7:0] |
| rd_addr_o | output | 1 | Address tag of the oldest word |
| empty_o | output | 1 | Queue empty |
| full_o | output | 1 | Queue full |
| idle_o | output | 1 | Idle line seen, next character is an address |
| irq_o | output | 1 | Receive interrupt |

## Verification
Two events can land in the same cycle: a character finishing while the queue is full, and a read removing a word. The bench first measures how many cycles pass from a tick-aligned start bit to the rise of `full_o` when the queue fills. It then starts the fifth character at the same tick phase and strobes a read exactly at that measured edge. The check passes if `full_o` stays high, the removed word is the oldest, and every word drained afterwards has its overrun tag clear. A sixth character then arrives with no read, and it must set overrun on the newest word only.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2
  } par_mode_e;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
    logic ovr;
  } rx_err_t;

  typedef struct packed {
    logic              addr;
    rx_err_t           err;
    logic [DATA_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr <= '1;
    else         sr <= {sr[STAGES-2:0], d_i};
  end

  assign q_o = sr[STAGES-1];
endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic [1:0]        par_mode_i,
  input  logic              two_stop_i,
  output logic              busy_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output rx_err_t           err_o
);
  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(DATA_W);
  localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [IW-1:0] TOP  = IW'(DATA_W - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2, S_HOLD
  } st_e;

  st_e               st;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     idx;
  logic [DATA_W-1:0] shreg;
  logic              ones, pbit, stop_bad;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  rx_err_t           err_q;

  logic par_en, odd, mid_tick, fin_brk, fin_bad, par_err;

  always_comb begin
    par_en   = (par_mode_i != PAR_NONE);
    odd      = (par_mode_i == PAR_ODD);
    mid_tick = tick_i && (cnt == LAST);
    fin_brk  = !(ones | rx_i);
    fin_bad  = stop_bad | !rx_i;
    par_err  = par_en && ((^shreg) ^ pbit ^ odd);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= S_IDLE;
      cnt      <= '0;
      idx      <= '0;
      shreg    <= '0;
      ones     <= 1'b0;
      pbit     <= 1'b0;
      stop_bad <= 1'b0;
      valid_q  <= 1'b0;
      data_q   <= '0;
      err_q    <= '0;
    end else begin
      valid_q <= 1'b0;
      unique case (st)
        S_IDLE: if (tick_i && !rx_i) begin
          st  <= S_START;
          cnt <= '0;
        end
        S_START: if (tick_i) begin
          if (cnt == MID) begin
            cnt <= '0;
            if (!rx_i) begin
              st       <= S_DATA;
              idx      <= '0;
              ones     <= 1'b0;
              pbit     <= 1'b0;
              stop_bad <= 1'b0;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DATA: if (tick_i) begin
          if (mid_tick) begin
            cnt   <= '0;
            shreg <= {rx_i, shreg[DATA_W-1:1]};
            ones  <= ones | rx_i;
            if (idx == TOP) st <= par_en ? S_PAR : S_STOP1;
            else            idx <= idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PAR: if (tick_i) begin
          if (mid_tick) begin
            cnt  <= '0;
            pbit <= rx_i;
            ones <= ones | rx_i;
            st   <= S_STOP1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STOP1, S_STOP2: if (tick_i) begin
          if (mid_tick) begin
            cnt <= '0;
            if (st == S_STOP1 && two_stop_i) begin
              stop_bad <= !rx_i;
              ones     <= ones | rx_i;
              st       <= S_STOP2;
            end else begin
              valid_q <= 1'b1;
              data_q  <= shreg;
              err_q   <= '{brk: fin_brk, frm: fin_bad | fin_brk, par: par_err, ovr: 1'b0};
              st      <= fin_brk ? S_HOLD : S_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_HOLD: if (tick_i && rx_i) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy_o  = (st != S_IDLE);
  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign err_o   = err_q;

  assert_start_reject_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == S_START && tick_i && cnt == MID && rx_i) |=> (st == S_IDLE && !valid_o));
  assert_valid_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  assert_no_par_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && par_mode_i == PAR_NONE) |-> !err_o.par);
  assert_break_tags_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && err_o.brk) |-> (err_o.frm && data_o == '0));
  assert_break_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && err_o.brk) |-> (st == S_HOLD));
endmodule

// File: rtl/srx_idle.sv
module srx_idle #(
  parameter int OVS       = 16,
  parameter int IDLE_BITS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rx_i,
  input  logic busy_i,
  input  logic mode_i,
  input  logic clr_i,
  output logic idle_o
);
  localparam int LIMIT = IDLE_BITS * OVS;
  localparam int CW    = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM   = CW'(LIMIT);
  localparam logic [CW-1:0] LIM_1 = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;
  logic          flag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      if (busy_i || !rx_i)          cnt <= '0;
      else if (tick_i && cnt != LIM) cnt <= cnt + 1'b1;

      if (clr_i) flag <= 1'b0;
      else if (mode_i && tick_i && !busy_i && rx_i && cnt == LIM_1) flag <= 1'b1;
    end
  end

  assign idle_o = flag;

  assert_idle_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !idle_o);
  assert_idle_mode_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_o) |-> $past(mode_i));
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
  import srx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      push_i,
  input  rx_entry_t entry_i,
  input  logic      pop_i,
  output rx_entry_t head_o,
  output logic      empty_o,
  output logic      full_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int NW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PMAX = AW'(DEPTH - 1);
  localparam logic [NW-1:0] NMAX = NW'(DEPTH);

  rx_entry_t     mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, last_ptr;
  logic [NW-1:0] count;
  logic          do_pop, accept, mark;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == PMAX) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    empty_o  = (count == '0);
    full_o   = (count == NMAX);
    do_pop   = pop_i && !empty_o;
    accept   = push_i && (!full_o || do_pop);
    mark     = push_i && full_o && !do_pop;
    last_ptr = (wr_ptr == '0) ? PMAX : wr_ptr - 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (accept)    mem[wr_ptr] <= entry_i;
    else if (mark) mem[last_ptr].err.ovr <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (accept) wr_ptr <= step(wr_ptr);
      if (do_pop) rd_ptr <= step(rd_ptr);
      unique case ({accept, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head_o = mem[rd_ptr];

  assert_count_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= NMAX);
  assert_full_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> (full_o && $stable(wr_ptr)));
  assert_swap_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && pop_i) |=> full_o);
  assert_pop_frees_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !empty_o && !push_i) |=> !full_o);
endmodule

// File: rtl/serial_rx_tagged.sv
module serial_rx_tagged
  import srx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int FIFO_DEPTH  = 4,
  parameter int IDLE_BITS   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        baud_tick_i,
  input  logic        rxd_i,
  input  logic [1:0]  par_mode_i,
  input  logic        two_stop_i,
  input  logic        idle_mode_i,
  input  logic [3:0]  irq_mask_i,
  input  logic        rd_en_i,
  output logic [11:0] rd_data_o,
  output logic        rd_addr_o,
  output logic        empty_o,
  output logic        full_o,
  output logic        idle_o,
  output logic        irq_o
);
  logic              rx_s, busy, chr_valid, idle_flag;
  logic [DATA_W-1:0] chr_data;
  rx_err_t           chr_err;
  rx_entry_t         new_entry, head;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(rxd_i), .q_o(rx_s)
  );

  srx_frame #(.OVS(OVS)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (baud_tick_i),
    .rx_i      (rx_s),
    .par_mode_i(par_mode_i),
    .two_stop_i(two_stop_i),
    .busy_o    (busy),
    .valid_o   (chr_valid),
    .data_o    (chr_data),
    .err_o     (chr_err)
  );

  srx_idle #(.OVS(OVS), .IDLE_BITS(IDLE_BITS)) u_idle (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(baud_tick_i),
    .rx_i  (rx_s),
    .busy_i(busy),
    .mode_i(idle_mode_i),
    .clr_i (chr_valid),
    .idle_o(idle_flag)
  );

  assign new_entry = '{addr: idle_flag, err: chr_err, data: chr_data};

  srx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (chr_valid),
    .entry_i(new_entry),
    .pop_i  (rd_en_i),
    .head_o (head),
    .empty_o(empty_o),
    .full_o (full_o)
  );

  assign rd_data_o = {head.err, head.data};
  assign rd_addr_o = head.addr;
  assign idle_o    = idle_flag;
  assign irq_o     = !empty_o && |(head.err & irq_mask_i);

  assert_irq_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !irq_o);
  assert_irq_masked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_mask_i == 4'b0000) |-> !irq_o);
  assert_flags_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_o && full_o));
endmodule

// File: tb/serial_rx_tagged_bench.sv
module serial_rx_tagged_bench;
  localparam int DEPTH = 4;
  localparam int TDIV  = 4;
  localparam int BITC  = 16 * TDIV;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        baud_tick_i = 1'b0;
  logic        rxd_i = 1'b1;
  logic [1:0]  par_mode_i = 2'd0;
  logic        two_stop_i = 1'b0;
  logic        idle_mode_i = 1'b0;
  logic [3:0]  irq_mask_i = 4'b0000;
  logic        rd_en_i = 1'b0;
  logic [11:0] rd_data_o;
  logic        rd_addr_o, empty_o, full_o, idle_o, irq_o;

  serial_rx_tagged u_serial_rx_tagged (
    .clk_i(clk_i), .rst_ni(rst_ni), .baud_tick_i(baud_tick_i), .rxd_i(rxd_i),
    .par_mode_i(par_mode_i), .two_stop_i(two_stop_i), .idle_mode_i(idle_mode_i),
    .irq_mask_i(irq_mask_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
    .rd_addr_o(rd_addr_o), .empty_o(empty_o), .full_o(full_o), .idle_o(idle_o),
    .irq_o(irq_o)
  );

  always #4 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  int edge_cnt = 0, tdiv = 0;
  int start_edge = 0, full_rise = 0, force_delta = 0;
  bit mon_en = 1'b1, sim_pop = 1'b0, force_on = 1'b0, full_prev = 1'b0, exp_addr = 1'b0;
  logic [12:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_head();
    logic [12:0] e;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R1 unexpected word", int'({rd_addr_o, rd_data_o}), 0);
    end else begin
      e = exp_q.pop_front();
      chk({rd_addr_o, rd_data_o} == e, "R1 word content", int'({rd_addr_o, rd_data_o}), int'(e));
    end
  endtask

  always @(posedge clk_i) edge_cnt <= edge_cnt + 1;

  always @(negedge clk_i) begin
    tdiv = (tdiv == TDIV - 1) ? 0 : tdiv + 1;
    baud_tick_i = (tdiv == TDIV - 1);
  end

  // monitor: scoreboard pop and optional forced read at a chosen edge
  always @(negedge clk_i) begin
    if (full_o && !full_prev) full_rise = edge_cnt;
    full_prev = full_o;
    if (rst_ni && ((mon_en && !empty_o) || (force_on && edge_cnt == start_edge + force_delta))) begin
      if (force_on && edge_cnt == start_edge + force_delta) force_on = 1'b0;
      check_head();
      rd_en_i = 1'b1;
    end else begin
      rd_en_i = 1'b0;
    end
  end

  task automatic drive_bit(input logic b);
    rxd_i = b;
    repeat (BITC) @(negedge clk_i);
  endtask

  task automatic align();
    @(posedge clk_i iff baud_tick_i);
    @(negedge clk_i);
    start_edge = edge_cnt;
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad_par, input logic s1, input logic s2);
    logic pb, brk, frm, par, has_par, two, tmp_ovr;
    logic [12:0] e, t;
    align();
    has_par = (par_mode_i != 2'd0);
    two     = two_stop_i;
    pb      = (^d) ^ (par_mode_i == 2'd2) ^ bad_par;
    brk     = (d == 8'h00) && (!has_par || !pb) && !s1 && (!two || !s2);
    frm     = !s1 || (two && !s2) || brk;
    par     = has_par && bad_par;
    tmp_ovr = 1'b0;
    e = {exp_addr, brk, frm, par, tmp_ovr, d};
    if (exp_q.size() >= DEPTH && !sim_pop) begin
      t = exp_q.pop_back();
      t[8] = 1'b1;
      exp_q.push_back(t);
    end else begin
      exp_q.push_back(e);
    end
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (has_par) drive_bit(pb);
    drive_bit(s1);
    if (two) drive_bit(s2);
    drive_bit(1'b1);
    drive_bit(1'b1);
  endtask

  task automatic send_break(input int nbits);
    align();
    exp_q.push_back({exp_addr, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00});
    rxd_i = 1'b0;
    repeat (nbits * BITC) @(negedge clk_i);
    drive_bit(1'b1);
    drive_bit(1'b1);
  endtask

  task automatic drain(input string req);
    mon_en = 1'b1;
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    chk(empty_o == 1'b1, "R7 empty after drain", int'(empty_o), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int d_cal;
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10 reset state
    chk(empty_o == 1'b1, "R10 empty", int'(empty_o), 1);
    chk(full_o == 1'b0, "R10 full", int'(full_o), 0);
    chk(irq_o == 1'b0, "R10 irq", int'(irq_o), 0);
    chk(idle_o == 1'b0, "R10 idle", int'(idle_o), 0);

    // R1 plain characters, no parity, one stop
    send_frame(8'h55, 0, 1, 1);
    send_frame(8'hA3, 0, 1, 1);
    send_frame(8'hFF, 0, 1, 1);
    send_frame(8'h00, 0, 1, 1);
    drain("R1 all words seen");

    // R2 short low glitch is not a start bit
    align();
    rxd_i = 1'b0;
    repeat (3 * TDIV) @(negedge clk_i);
    rxd_i = 1'b1;
    repeat (2 * BITC) @(negedge clk_i);
    chk(empty_o == 1'b1, "R2 glitch ignored", int'(empty_o), 1);
    send_frame(8'h3C, 0, 1, 1);
    drain("R2 frame after glitch");

    // R3 framing, single stop low
    send_frame(8'h81, 0, 0, 1);
    // R4 parity modes
    par_mode_i = 2'd1;
    send_frame(8'h5A, 0, 1, 1);
    send_frame(8'h5A, 1, 1, 1);
    send_frame(8'h07, 1, 1, 1);
    drain("R4 even parity words");
    par_mode_i = 2'd2;
    send_frame(8'h01, 0, 1, 1);
    send_frame(8'h01, 1, 1, 1);
    send_frame(8'hF0, 1, 1, 1);
    drain("R4 odd parity words");
    par_mode_i = 2'd0;

    // R3 two stop bits
    two_stop_i = 1'b1;
    send_frame(8'h96, 0, 1, 1);
    send_frame(8'h96, 0, 1, 0);
    send_frame(8'h69, 0, 0, 1);
    drain("R3 two stop words");
    two_stop_i = 1'b0;

    // R6 break: line low 20 bit times yields one tagged word only
    send_break(20);
    send_frame(8'h42, 0, 1, 1);
    drain("R6 break then normal");

    // R7 fill to full, measure push edge
    mon_en = 1'b0;
    send_frame(8'h11, 0, 1, 1);
    send_frame(8'h22, 0, 1, 1);
    send_frame(8'h33, 0, 1, 1);
    chk(full_o == 1'b0, "R7 three words not full", int'(full_o), 0);
    send_frame(8'h44, 0, 1, 1);
    d_cal = full_rise - start_edge;
    chk(full_o == 1'b1, "R7 full at four", int'(full_o), 1);
    chk(empty_o == 1'b0, "R7 not empty when full", int'(empty_o), 0);

    // R5 completion and read in the same cycle
    sim_pop = 1'b1;
    force_delta = d_cal - 1;
    force_on = 1'b1;
    send_frame(8'h55, 0, 1, 1);
    sim_pop = 1'b0;
    chk(force_on == 1'b0, "R5 forced read issued", int'(force_on), 0);
    chk(full_o == 1'b1, "R5 still full after swap", int'(full_o), 1);
    // R5 overrun: sixth character dropped, newest word tagged
    send_frame(8'h66, 0, 1, 1);
    chk(full_o == 1'b1, "R5 full after overrun", int'(full_o), 1);
    irq_mask_i = 4'b0001;
    @(negedge clk_i);
    chk(irq_o == 1'b0, "R8 overrun not on oldest", int'(irq_o), 0);
    irq_mask_i = 4'b0000;
    drain("R5 drained words with overrun on newest");

    // R8 interrupt masking with a parity error at the head
    mon_en = 1'b0;
    par_mode_i = 2'd1;
    send_frame(8'h5A, 1, 1, 1);
    irq_mask_i = 4'b0010;
    @(negedge clk_i);
    chk(irq_o == 1'b1, "R8 parity enabled", int'(irq_o), 1);
    irq_mask_i = 4'b1101;
    @(negedge clk_i);
    chk(irq_o == 1'b0, "R8 parity masked", int'(irq_o), 0);
    irq_mask_i = 4'b0000;
    par_mode_i = 2'd0;
    drain("R8 word drained");

    // R9 idle-line address tagging
    send_frame(8'h10, 0, 1, 1);
    idle_mode_i = 1'b1;
    @(negedge clk_i);
    chk(idle_o == 1'b0, "R9 idle not yet", int'(idle_o), 0);
    rxd_i = 1'b1;
    repeat (12 * BITC) @(negedge clk_i);
    chk(idle_o == 1'b1, "R9 idle detected", int'(idle_o), 1);
    exp_addr = 1'b1;
    send_frame(8'hC5, 0, 1, 1);
    exp_addr = 1'b0;
    chk(idle_o == 1'b0, "R9 idle cleared by char", int'(idle_o), 0);
    send_frame(8'hC6, 0, 1, 1);
    drain("R9 address tagged words");
    idle_mode_i = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule